// File: doc/BRIEF.md
# Auto-Reload Up-Counter with Gated Update Events

This block is a 16-bit up-counter driven through a programmable prescaler. The counter wraps to zero when it reaches the active reload limit. Both the prescaler divisor and the reload limit sit in shadow registers. These copies change only when an update event occurs. There is one exception: the reload limit may instead be written straight through. A small control word selects how update events behave:

- An event can be kept from happening at all.
- The event can be restricted to wraps only, for the purpose of raising the update flag.
- The counter can be made to stop after a single period.

Software writes the control word, the prescaler value and the reload value, and clears the sticky flag, through a simple select/data write port. It can also force an update with a one-cycle pulse. A separate slave input reinitialises the counters and counts as an update source. A free-running divider produces a sampling enable at 1, 1/2 or 1/4 of the clock rate for downstream filtering or dead-time logic.

Top module: `art_timer`

## Requirements
- R1: After reset, the counter is 0, the update flag and the DMA strobe are 0, the control readback is 0, the active reload value is 16'hFFFF and the active prescaler value is 0.
- R2: With the run bit (control bit 0) at 1, the counter advances once every PSC+1 clocks. When it equals the active reload value on such a tick, it wraps to 0 on that same edge. On that edge it also sets the update flag and drives the DMA strobe high for exactly one cycle.
- R3: With reload buffering (control bit 4) at 0, a write to the reload value (select 2) changes the active reload value on the next clock edge.
- R4: With reload buffering at 1, a reload write does not change the active reload value until the next update event.
- R5: A prescaler write (select 1) changes the active prescaler value only at an update event.
- R6: With single-shot (control bit 3) at 1, an update event clears the run bit, and the counter stays at 0 afterwards.
- R7: With wrap-only flagging (control bit 2) at 1, a software update pulse or a slave pulse still reloads the shadows but sets neither the flag nor the DMA strobe. A wrap still sets both.
- R8: With update suppression (control bit 1) at 1, no update event occurs. The shadow values hold, and the flag stays 0.
- R9: A software update pulse while running, or a slave pulse at any time, clears the counter on the next edge, even with updates suppressed. A software update pulse while stopped leaves the counter value unchanged, but it still performs the update.
- R10: The sampling-division field (control bits 6:5) gives a sampling enable every 1 clock (code 0), every 2 clocks (code 1) or every 4 clocks (code 2). A write carrying code 3 leaves the field at its previous value.
- R11: Control readback bits other than bits 6:0 always read 0.
- R12: The update flag stays set until a write to select 3. If a set condition and a clear write fall on the same edge, the set condition wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 prescaler, 2 reload, 3 flag clear |
| wr_data | input | 16 | Write data |
| ug_pulse | input | 1 | Software update-generate pulse |
| slv_reset | input | 1 | Slave reset/update pulse |
| ctrl_rd | output | 16 | Control word readback |
| cnt_o | output | 16 | Counter value |
| arr_act_o | output | 16 | Active reload value |
| psc_act_o | output | 16 | Active prescaler value |
| upd_flag | output | 1 | Sticky update flag |
| dma_req | output | 1 | One-cycle update request strobe |
| sample_en | output | 1 | Divided sampling enable |

## Verification
The hardest case to reach is a software update pulse that arrives while the counter is stopped at a nonzero value. The stimulus runs the counter for a known number of clocks, then writes the run bit low. That write still consumes one counting edge. Only then does it pulse the update input, and the counter must not move while the shadows reload. A second hard case is reinitialisation under update suppression. There the counter must clear while the flag and the shadows stay put. The bench reaches it by enabling suppression together with run, letting the count build up, and then pulsing each reset source.

// File: rtl/art_pkg.sv
`timescale 1ns/1ps
package art_pkg;

  localparam int DATA_W = 16;

  // Write targets of the simple register port
  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_PSC   = 2'd1;
  localparam logic [1:0] SEL_ARR   = 2'd2;
  localparam logic [1:0] SEL_CLR   = 2'd3;

  localparam logic [1:0] DIV_RESERVED = 2'b11;

  typedef struct packed {
    logic [1:0] div;   // bits 6:5
    logic       arpe;  // bit 4
    logic       opm;   // bit 3
    logic       urs;   // bit 2
    logic       udis;  // bit 1
    logic       run;   // bit 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Mask applied to the sampling divider count: enable when masked bits are 0
  function automatic logic [1:0] div_mask(input logic [1:0] code);
    case (code)
      2'b01:   return 2'b01;
      2'b10:   return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  // Decode a control write, keeping the old division on the reserved code
  function automatic ctrl_t ctrl_decode(input logic [DATA_W-1:0] d, input ctrl_t old);
    ctrl_t c;
    c.run  = d[0];
    c.udis = d[1];
    c.urs  = d[2];
    c.opm  = d[3];
    c.arpe = d[4];
    c.div  = (d[6:5] == DIV_RESERVED) ? old.div : d[6:5];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_pack(input ctrl_t c);
    logic [DATA_W-1:0] r;
    r = '0;
    r[CTRL_W-1:0] = c;
    return r;
  endfunction

endpackage

// File: rtl/art_prescaler.sv
`timescale 1ns/1ps
module art_prescaler #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          reinit,
  input  logic [PW-1:0] psc_act,
  output logic          tick
);
  logic [PW-1:0] pcnt;

  assign tick = run && (pcnt == psc_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (reinit)  pcnt <= '0;
    else if (tick)    pcnt <= '0;
    else if (run)     pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/art_counter.sv
`timescale 1ns/1ps
module art_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          reinit,
  input  logic [CW-1:0] arr_act,
  output logic [CW-1:0] cnt,
  output logic          ovf_evt
);
  assign ovf_evt = tick && (cnt == arr_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (reinit)   cnt <= '0;
    else if (ovf_evt)  cnt <= '0;
    else if (tick)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/art_update_ctrl.sv
`timescale 1ns/1ps
module art_update_ctrl (
  input  logic ovf_evt,
  input  logic ug,
  input  logic slv,
  input  logic run,
  input  logic udis,
  input  logic urs,
  output logic reinit,
  output logic upd_evt,
  output logic flag_set
);
  // Counter reinit: software pulse only while running, slave pulse always
  assign reinit   = (ug && run) || slv;
  // Update event: any source, gated by suppression
  assign upd_evt  = !udis && (ovf_evt || ug || slv);
  // Flag/request source: restricted to wraps when urs is set
  assign flag_set = upd_evt && (!urs || ovf_evt);
endmodule

// File: rtl/art_sample_div.sv
`timescale 1ns/1ps
module art_sample_div
  import art_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] div,
  output logic       sample_en
);
  logic [1:0] dcnt;

  assign sample_en = ((dcnt & div_mask(div)) == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt <= '0;
    else        dcnt <= dcnt + 1'b1;
  end
endmodule

// File: rtl/art_timer.sv
`timescale 1ns/1ps
module art_timer
  import art_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ug_pulse,
  input  logic              slv_reset,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic [CW-1:0]     cnt_o,
  output logic [CW-1:0]     arr_act_o,
  output logic [PW-1:0]     psc_act_o,
  output logic              upd_flag,
  output logic              dma_req,
  output logic              sample_en
);
  localparam logic [CW-1:0] ARR_RST = {CW{1'b1}};

  ctrl_t         ctrl_q;
  logic [PW-1:0] psc_pre, psc_act;
  logic [CW-1:0] arr_pre, arr_act;
  logic          tick, ovf_evt, upd_evt, flag_set, reinit;
  logic          wr_ctrl, wr_psc, wr_arr, wr_clr;

  assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
  assign wr_psc  = wr_en && (wr_sel == SEL_PSC);
  assign wr_arr  = wr_en && (wr_sel == SEL_ARR);
  assign wr_clr  = wr_en && (wr_sel == SEL_CLR);

  art_update_ctrl u_upd (
    .ovf_evt  (ovf_evt),
    .ug       (ug_pulse),
    .slv      (slv_reset),
    .run      (ctrl_q.run),
    .udis     (ctrl_q.udis),
    .urs      (ctrl_q.urs),
    .reinit   (reinit),
    .upd_evt  (upd_evt),
    .flag_set (flag_set)
  );

  art_prescaler #(.PW(PW)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run),
    .reinit  (reinit),
    .psc_act (psc_act),
    .tick    (tick)
  );

  art_counter #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .reinit  (reinit),
    .arr_act (arr_act),
    .cnt     (cnt_o),
    .ovf_evt (ovf_evt)
  );

  art_sample_div u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .div       (ctrl_q.div),
    .sample_en (sample_en)
  );

  // Control word; single-shot clears run on an update unless software writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ctrl_q <= '0;
    else if (wr_ctrl)                ctrl_q <= ctrl_decode(wr_data, ctrl_q);
    else if (upd_evt && ctrl_q.opm)  ctrl_q.run <= 1'b0;
  end

  // Prescaler preload and shadow
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_pre <= '0;
      psc_act <= '0;
    end else begin
      if (wr_psc)  psc_pre <= wr_data[PW-1:0];
      if (upd_evt) psc_act <= psc_pre;
    end
  end

  // Reload preload and shadow; direct path when buffering is off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_pre <= ARR_RST;
      arr_act <= ARR_RST;
    end else begin
      if (wr_arr) arr_pre <= wr_data[CW-1:0];
      if (wr_arr && !ctrl_q.arpe)  arr_act <= wr_data[CW-1:0];
      else if (upd_evt)            arr_act <= arr_pre;
    end
  end

  // Sticky flag and one-cycle request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_flag <= 1'b0;
      dma_req  <= 1'b0;
    end else begin
      dma_req <= flag_set;
      if (flag_set)    upd_flag <= 1'b1;
      else if (wr_clr) upd_flag <= 1'b0;
    end
  end

  assign ctrl_rd   = ctrl_pack(ctrl_q);
  assign arr_act_o = arr_act;
  assign psc_act_o = psc_act;

endmodule

// File: rtl/art_timer_chk.sv
`timescale 1ns/1ps
module art_timer_chk #(
  parameter int CW = 16,
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_ctrl,
  input logic          run,
  input logic          udis,
  input logic          urs,
  input logic          opm,
  input logic          upd_evt,
  input logic          ovf_evt,
  input logic [CW-1:0] cnt,
  input logic [PW-1:0] psc_act,
  input logic          upd_flag,
  input logic          dma_req
);
  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt == '0));

  // R12
  dma_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> upd_flag);

  // R5
  psc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(psc_act));

  // R6
  single_shot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opm && upd_evt && !wr_ctrl) |=> !run);

  // R8
  suppressed_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    udis |-> !upd_evt);

  // R7
  wrap_only_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (urs && !ovf_evt) |=> !dma_req);
endmodule

bind art_timer art_timer_chk #(.CW(CW), .PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_ctrl  (wr_ctrl),
  .run      (ctrl_q.run),
  .udis     (ctrl_q.udis),
  .urs      (ctrl_q.urs),
  .opm      (ctrl_q.opm),
  .upd_evt  (upd_evt),
  .ovf_evt  (ovf_evt),
  .cnt      (cnt_o),
  .psc_act  (psc_act),
  .upd_flag (upd_flag),
  .dma_req  (dma_req)
);

// File: tb/tb_art_timer.sv
`timescale 1ns/1ps
module tb_art_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        ug_pulse = 1'b0;
  logic        slv_reset = 1'b0;
  logic [15:0] ctrl_rd, cnt_o, arr_act_o, psc_act_o;
  logic        upd_flag, dma_req, sample_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  art_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ug_pulse(ug_pulse), .slv_reset(slv_reset), .ctrl_rd(ctrl_rd), .cnt_o(cnt_o),
    .arr_act_o(arr_act_o), .psc_act_o(psc_act_o), .upd_flag(upd_flag),
    .dma_req(dma_req), .sample_en(sample_en)
  );

  // Control bit values from the requirements
  localparam logic [15:0] B_RUN  = 16'h0001;
  localparam logic [15:0] B_UDIS = 16'h0002;
  localparam logic [15:0] B_URS  = 16'h0004;
  localparam logic [15:0] B_OPM  = 16'h0008;
  localparam logic [15:0] B_ARPE = 16'h0010;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // All helpers start and end at a falling edge
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ug();
    ug_pulse = 1'b1; @(negedge clk); ug_pulse = 1'b0;
  endtask

  task automatic slv();
    slv_reset = 1'b1; @(negedge clk); slv_reset = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; ug_pulse = 1'b0; slv_reset = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "cnt", cnt_o, 0);
    chk("R1", "flag", upd_flag, 0);
    chk("R1", "dma", dma_req, 0);
    chk("R1", "ctrl", ctrl_rd, 0);
    chk("R1", "arr", arr_act_o, 16'hFFFF);
    chk("R1", "psc", psc_act_o, 0);
  endtask

  task automatic t_free_run();
    do_reset();
    wr(2, 16'd3);
    wr(0, B_RUN);
    tick(3);
    chk("R2", "cnt before wrap", cnt_o, 3);
    chk("R2", "flag before wrap", upd_flag, 0);
    tick(1);
    chk("R2", "cnt at wrap", cnt_o, 0);
    chk("R2", "flag at wrap", upd_flag, 1);
    chk("R2", "dma at wrap", dma_req, 1);
    tick(1);
    chk("R2", "dma one cycle", dma_req, 0);
    chk("R12", "flag sticky", upd_flag, 1);
    chk("R2", "cnt after wrap", cnt_o, 1);
  endtask

  task automatic t_prescale();
    do_reset();
    wr(1, 16'd2);
    chk("R5", "psc before update", psc_act_o, 0);
    ug();
    chk("R5", "psc after update", psc_act_o, 2);
    wr(3, 16'd0);
    chk("R12", "flag cleared", upd_flag, 0);
    wr(2, 16'd1);
    wr(0, B_RUN);
    tick(2);
    chk("R2", "cnt within first period", cnt_o, 0);
    tick(1);
    chk("R2", "cnt after one prescaled tick", cnt_o, 1);
    wr(1, 16'd0);
    chk("R5", "psc held after write", psc_act_o, 2);
    tick(1);
    chk("R2", "flag before prescaled wrap", upd_flag, 0);
    tick(1);
    chk("R2", "prescaled wrap cnt", cnt_o, 0);
    chk("R2", "prescaled wrap flag", upd_flag, 1);
    chk("R5", "psc loaded at wrap", psc_act_o, 0);
  endtask

  task automatic t_reload();
    do_reset();
    wr(2, 16'd7);
    chk("R3", "direct reload", arr_act_o, 7);
    wr(0, B_ARPE);
    wr(2, 16'd9);
    chk("R4", "buffered reload held", arr_act_o, 7);
    tick(2);
    chk("R4", "buffered reload still held", arr_act_o, 7);
    ug();
    chk("R4", "buffered reload at update", arr_act_o, 9);
  endtask

  task automatic t_single_shot();
    do_reset();
    wr(2, 16'd2);
    wr(0, B_OPM | B_RUN);
    tick(3);
    chk("R6", "run cleared", ctrl_rd, B_OPM);
    chk("R6", "cnt at stop", cnt_o, 0);
    chk("R6", "flag at stop", upd_flag, 1);
    tick(4);
    chk("R6", "cnt stays", cnt_o, 0);
  endtask

  task automatic t_wrap_only();
    do_reset();
    wr(0, B_URS);
    wr(1, 16'd5);
    ug();
    chk("R7", "shadow loads", psc_act_o, 5);
    chk("R7", "no dma on pulse", dma_req, 0);
    chk("R7", "no flag on pulse", upd_flag, 0);
    wr(1, 16'd0);
    slv();
    chk("R7", "slave loads shadow", psc_act_o, 0);
    chk("R7", "no flag on slave", upd_flag, 0);
    wr(2, 16'd1);
    wr(0, B_URS | B_RUN);
    tick(2);
    chk("R7", "wrap flag", upd_flag, 1);
    chk("R7", "wrap dma", dma_req, 1);
  endtask

  task automatic t_suppress();
    do_reset();
    wr(1, 16'd3);
    wr(2, 16'd100);
    wr(0, B_UDIS | B_RUN);
    tick(5);
    chk("R9", "counting", cnt_o, 5);
    ug();
    chk("R9", "sw reinit under suppression", cnt_o, 0);
    chk("R8", "psc shadow kept", psc_act_o, 0);
    chk("R8", "no flag", upd_flag, 0);
    tick(3);
    slv();
    chk("R9", "slave reinit", cnt_o, 0);
    chk("R8", "no flag after slave", upd_flag, 0);
    chk("R8", "reload kept", arr_act_o, 100);
  endtask

  task automatic t_stopped_ug();
    do_reset();
    wr(0, B_RUN);
    tick(4);
    wr(0, 16'h0000);
    chk("R9", "cnt at stop", cnt_o, 5);
    wr(1, 16'd4);
    ug();
    chk("R9", "stopped counter unchanged", cnt_o, 5);
    chk("R9", "update still reloads", psc_act_o, 4);
    chk("R9", "update still flags", upd_flag, 1);
  endtask

  task automatic count_samples(input string req, input int exp);
    int n = 0;
    for (int i = 0; i < 8; i++) begin
      if (sample_en) n++;
      tick(1);
    end
    chk(req, "sample enables in 8 clocks", n, exp);
  endtask

  task automatic t_divider();
    do_reset();
    count_samples("R10", 8);
    wr(0, 16'h0020);
    count_samples("R10", 4);
    wr(0, 16'h0040);
    count_samples("R10", 2);
    wr(0, 16'h0060);
    chk("R10", "reserved code ignored", ctrl_rd, 16'h0040);
    count_samples("R10", 2);
  endtask

  task automatic t_readback();
    do_reset();
    wr(0, 16'hFF9E);
    chk("R11", "reserved bits zero", ctrl_rd, 16'h001E);
    chk("R11", "upper bits zero", ctrl_rd & 16'hFF80, 0);
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_prescale();
    t_reload();
    t_single_shot();
    t_wrap_only();
    t_suppress();
    t_stopped_ug();
    t_divider();
    t_readback();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule